// File: doc/BRIEF.md
# Decimating Entropy Bit Collector

This block gathers raw random bits from a free-running single-bit entropy input and hands them to software through a small 32-bit register window. Software programs a decimation period and an output length, then sets a start flag. The collector takes one bit each time the period expires and packs the bits into a staging buffer. Once the requested number of bits has arrived, it copies the buffer into the readable data words and clears the start flag.

The oscillator that produces the entropy is outside the block. A two-bit speed field is only stored and driven out to it. The control register takes masked writes. The upper half of each write word selects which of the lower control bits change. A separate reset-control register lets software wipe the collector state without a hardware reset.

Top module: `entropy_collector`

## Requirements
- R1: After `rstN` is low, every register reads 0 and `oscSpeed` is 0.
- R2: A write to the control register (offset 0x400) changes control bit k only when write bit 16+k is 1; bit k then takes write bit k. Defined control bits are 0 start, 1 enable, 3:2 speed and 5:4 length. Other bits read as 0.
- R3: `oscSpeed` always equals control bits 3:2.
- R4: The sample register (offset 0x404, 32 bits, read/write) sets the period N. While start and enable are both 1, one entropy bit is taken every N clock cycles. A value of 0 acts as 1.
- R5: The length code gives 64 bits for 0, 128 for 1, 192 for 2 and 256 for 3. Start reads 1 while a run is in progress. It clears by itself once that many bits are taken.
- R6: Bit i of a run, counted from 0, lands in data word i/32 at bit i%32. Data word j is at offset 0x410+4j for j from 0 to 7. Words past the selected length read 0 after the run.
- R7: While a run is in progress, the data words keep the previous run's contents. They change only in the cycle start clears.
- R8: With start at 1 and enable at 0, no bit is taken and start stays 1. Sampling resumes when enable is raised.
- R9: A masked write of 0 to start during a run stops it. The data words are left unchanged, and a later start begins from bit 0.
- R10: Writing 1 to bit 0 of the reset-control register (offset 0x004) clears the control register, the counters and all data words. The sample register keeps its value.
- R11: A read presents the addressed register on `busRdata` one clock after `busRd`. The reset-control register and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe |
| busAddr | input | 12 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| entropyBit | input | 1 | Raw entropy input |
| oscSpeed | output | 2 | Oscillator speed setting |

## Verification
Runs are tried at three periods: 1, 0 (which must behave like 1) and 3. They cover all four length codes, so an off-by-one in the period count or in the last bit index shows as a shifted word or a late start clear. A pseudo-random entropy stream makes packing order visible. Reads taken during a run tell staged data apart from committed data. A stalled run with enable low, an aborted run and a soft wipe separate the paths that must leave the data words untouched from those that must clear them.

// File: rtl/entcol_pkg.sv
package entcol_pkg;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFF_WIPE = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 12'h400;
  localparam logic [ADDR_W-1:0] OFF_PERIOD = 12'h404;
  localparam logic [ADDR_W-1:0] OFF_DATA = 12'h410;

  // strobes from control to datapath
  typedef struct packed {
    logic wipe;      // soft clear of everything
    logic clearAsm;  // new run begins
    logic sample;    // take one entropy bit
    logic commit;    // last bit of run: publish
  } colStrobe_t;
endpackage

// File: rtl/entcol_ctrl.sv
module entcol_ctrl
  import entcol_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int UNIT_BITS = 64,
  parameter int IDX_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWr,
  input  logic                periodWr,
  input  logic                wipeWr,
  input  logic [31:0]         wrData,
  output colStrobe_t          stb,
  output logic [IDX_W-1:0]    bitIdx,
  output logic [5:0]          ctrlBits,
  output logic [SAMPLE_W-1:0] periodVal
);
  logic startQ, enableQ;
  logic [1:0] speedQ, lenQ;
  logic [SAMPLE_W-1:0] periodQ, cntQ, limit;
  logic [IDX_W-1:0] idxQ, lastIdx;
  logic [15:0] mask, val;
  logic running, tick, startSet, stopHit, sampleHit, lastHit;

  assign mask = wrData[31:16];
  assign val = wrData[15:0];
  assign limit = (periodQ == '0) ? '0 : periodQ - 1'b1;
  assign tick = (cntQ >= limit);
  assign lastIdx = IDX_W'((int'(lenQ) + 1) * UNIT_BITS - 1);
  assign running = startQ && enableQ;
  assign startSet = ctrlWr && mask[0] && val[0] && !startQ && !wipeWr;
  assign stopHit = ctrlWr && mask[0] && !val[0] && startQ && !wipeWr;
  assign sampleHit = running && tick && !stopHit && !wipeWr;
  assign lastHit = sampleHit && (idxQ >= lastIdx);

  assign stb.wipe = wipeWr;
  assign stb.clearAsm = startSet;
  assign stb.sample = sampleHit;
  assign stb.commit = lastHit;
  assign bitIdx = idxQ;
  assign ctrlBits = {lenQ, speedQ, enableQ, startQ};
  assign periodVal = periodQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ <= 1'b0;
      enableQ <= 1'b0;
      speedQ <= '0;
      lenQ <= '0;
      periodQ <= '0;
      cntQ <= '0;
      idxQ <= '0;
    end else if (wipeWr) begin
      startQ <= 1'b0;
      enableQ <= 1'b0;
      speedQ <= '0;
      lenQ <= '0;
      cntQ <= '0;
      idxQ <= '0;
    end else begin
      if (periodWr) periodQ <= wrData[SAMPLE_W-1:0];
      if (ctrlWr) begin
        if (mask[0]) startQ <= val[0];
        if (mask[1]) enableQ <= val[1];
        if (mask[2]) speedQ[0] <= val[2];
        if (mask[3]) speedQ[1] <= val[3];
        if (mask[4]) lenQ[0] <= val[4];
        if (mask[5]) lenQ[1] <= val[5];
      end
      if (lastHit) startQ <= 1'b0;
      if (startSet || stopHit) begin
        cntQ <= '0;
        idxQ <= '0;
      end else if (sampleHit) begin
        cntQ <= '0;
        idxQ <= lastHit ? '0 : idxQ + 1'b1;
      end else if (running) begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  // R5
  start_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startQ) |-> $past(stb.commit || stopHit || wipeWr));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startQ && !enableQ && !ctrlWr && !wipeWr) |=> $stable(idxQ));
endmodule

// File: rtl/entcol_data.sv
module entcol_data
  import entcol_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int WORD_W = 32,
  parameter int IDX_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  colStrobe_t               stb,
  input  logic [IDX_W-1:0]         bitIdx,
  input  logic                     entBit,
  input  logic [$clog2(WORDS)-1:0] rdSel,
  output logic [WORD_W-1:0]        rdWord
);
  localparam int TOTAL = WORDS * WORD_W;

  logic [TOTAL-1:0] asmQ, asmNext, visQ;
  logic [WORD_W-1:0] words [WORDS];

  always_comb begin
    asmNext = asmQ;
    if (stb.sample) asmNext[bitIdx] = entBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asmQ <= '0;
      visQ <= '0;
    end else if (stb.wipe) begin
      asmQ <= '0;
      visQ <= '0;
    end else begin
      if (stb.clearAsm) asmQ <= '0;
      else if (stb.sample) asmQ <= asmNext;
      if (stb.commit) visQ <= asmNext;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : gWord
    assign words[g] = visQ[g*WORD_W +: WORD_W];
  end

  assign rdWord = words[rdSel];

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wipe, stb.clearAsm, stb.sample}));

  // R7
  commit_in_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> stb.sample);

  // R7
  vis_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.commit && !stb.wipe) |=> $stable(visQ));
endmodule

// File: rtl/entropy_collector.sv
module entropy_collector
  import entcol_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int WORDS = 8,
  parameter int UNIT_BITS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [11:0]       busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              entropyBit,
  output logic [1:0]        oscSpeed
);
  localparam int WORD_W = 32;
  localparam int IDX_W = $clog2(WORDS * WORD_W);
  localparam int SEL_W = $clog2(WORDS);
  localparam logic [ADDR_W-1:0] DATA_END = OFF_DATA + ADDR_W'(WORDS * 4);

  colStrobe_t stb;
  logic [IDX_W-1:0] bitIdx;
  logic [5:0] ctrlBits;
  logic [SAMPLE_W-1:0] periodVal;
  logic [WORD_W-1:0] dataWord;
  logic [ADDR_W-1:0] dataOff;
  logic [SEL_W-1:0] rdSel;
  logic isData, ctrlWr, periodWr, wipeWr;
  logic [31:0] rdMux, rdQ;

  assign ctrlWr = busWr && (busAddr == OFF_CTRL);
  assign periodWr = busWr && (busAddr == OFF_PERIOD);
  assign wipeWr = busWr && (busAddr == OFF_WIPE) && busWdata[0];
  assign isData = (busAddr >= OFF_DATA) && (busAddr < DATA_END) && (busAddr[1:0] == 2'b00);
  assign dataOff = busAddr - OFF_DATA;
  assign rdSel = dataOff[SEL_W+1:2];

  entcol_ctrl #(.SAMPLE_W(SAMPLE_W), .UNIT_BITS(UNIT_BITS), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .periodWr(periodWr), .wipeWr(wipeWr),
    .wrData(busWdata), .stb(stb), .bitIdx(bitIdx), .ctrlBits(ctrlBits), .periodVal(periodVal)
  );

  entcol_data #(.WORDS(WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .bitIdx(bitIdx), .entBit(entropyBit),
    .rdSel(rdSel), .rdWord(dataWord)
  );

  always_comb begin
    rdMux = '0;
    if (busAddr == OFF_CTRL) rdMux = {26'd0, ctrlBits};
    else if (busAddr == OFF_PERIOD) rdMux = 32'(periodVal);
    else if (isData) rdMux = dataWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdQ <= '0;
    else if (busRd) rdQ <= rdMux;
  end

  assign busRdata = rdQ;
  assign oscSpeed = ctrlBits[3:2];

  // R11
  wipe_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == OFF_WIPE) |=> (busRdata == 32'd0));
endmodule

// File: tb/sim_entropy_collector.sv
module sim_entropy_collector;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic entropyBit = 1'b0;
  logic [1:0] oscSpeed;

  int compared = 0, mismatched = 0;
  bit done = 0;
  string curReq = "R1";
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;  // 125 MHz

  entropy_collector u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .entropyBit(entropyBit), .oscSpeed(oscSpeed)
  );

  // entropy stream
  always @(negedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    entropyBit = lfsr[0];
  end

  // behavioural reference model
  logic mStart, mEn;
  logic [1:0] mSpd, mLen;
  logic [31:0] mPeriod, mRd;
  longint mCnt;
  int mIdx;
  logic [255:0] mAsm, mVis;

  function automatic logic [31:0] modelRead(logic [11:0] a);
    if (a == 12'h400) return {26'd0, mLen, mSpd, mEn, mStart};
    if (a == 12'h404) return mPeriod;
    if (a >= 12'h410 && a < 12'h430 && a[1:0] == 2'b00) return mVis[(int'(a - 12'h410) / 4) * 32 +: 32];
    return 32'd0;
  endfunction

  always @(posedge clk or negedge rstN) begin : mdl
    logic [31:0] rdNext;
    logic [15:0] m, v;
    logic samp, startSet, stopNow, finish;
    longint nEff;
    int lenBits;
    if (!rstN) begin
      mStart = 0; mEn = 0; mSpd = 0; mLen = 0; mPeriod = 0; mRd = 0;
      mCnt = 0; mIdx = 0; mAsm = '0; mVis = '0;
    end else begin
      rdNext = modelRead(busAddr);
      if (busWr && busAddr == 12'h004 && busWdata[0]) begin
        mStart = 0; mEn = 0; mSpd = 0; mLen = 0; mCnt = 0; mIdx = 0; mAsm = '0; mVis = '0;
      end else begin
        m = busWdata[31:16]; v = busWdata[15:0];
        nEff = (mPeriod == 0) ? 1 : longint'(mPeriod);
        lenBits = (int'(mLen) + 1) * 64;
        startSet = busWr && busAddr == 12'h400 && m[0] && v[0] && !mStart;
        stopNow = busWr && busAddr == 12'h400 && m[0] && !v[0] && mStart;
        samp = mStart && mEn && (mCnt >= nEff - 1) && !stopNow;
        finish = 0;
        if (startSet) begin mCnt = 0; mIdx = 0; mAsm = '0; end
        else if (stopNow) begin mCnt = 0; mIdx = 0; end
        else if (samp) begin
          mAsm[mIdx] = entropyBit;
          mCnt = 0;
          if (mIdx >= lenBits - 1) begin mVis = mAsm; mIdx = 0; finish = 1; end
          else mIdx = mIdx + 1;
        end else if (mStart && mEn) mCnt = mCnt + 1;
        if (busWr && busAddr == 12'h404) mPeriod = busWdata;
        if (busWr && busAddr == 12'h400) begin
          if (m[0]) mStart = v[0];
          if (m[1]) mEn = v[1];
          if (m[2]) mSpd[0] = v[2];
          if (m[3]) mSpd[1] = v[3];
          if (m[4]) mLen[0] = v[4];
          if (m[5]) mLen[1] = v[5];
        end
        if (finish) mStart = 0;
      end
      if (busRd) mRd = rdNext;
    end
  end

  // compare every clock
  always @(negedge clk) begin
    if (rstN && !done) begin
      compared++;
      if (busRdata !== mRd) begin
        mismatched++;
        $display("FAIL %s busRdata actual %h expected %h at %0t", curReq, busRdata, mRd, $time);
      end
      compared++;
      if (oscSpeed !== mSpd) begin
        mismatched++;  // R3
        $display("FAIL R3 oscSpeed actual %0d expected %0d at %0t", oscSpeed, mSpd, $time);
      end
    end
  end

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); #1;
    busWr = 0;
  endtask

  task automatic busRead(input logic [11:0] a);
    @(negedge clk); #1;
    busRd = 1; busAddr = a;
    @(negedge clk); #1;
    busRd = 0;
  endtask

  task automatic readAll();
    busRead(12'h400);
    busRead(12'h404);
    busRead(12'h004);
    for (int j = 0; j < 8; j++) busRead(12'h410 + 12'(j * 4));
  endtask

  task automatic waitDone();
    for (int k = 0; k < 20000; k++) begin
      busRead(12'h400);
      if (busRdata[0] == 1'b0) break;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired in %s", curReq);
      summary();
    end
  end

  initial begin
    idle(3); #1; rstN = 1;
    curReq = "R1"; readAll();
    curReq = "R11"; busWrite(12'h404, 32'd5); busRead(12'h404); busRead(12'h408); busRead(12'h40C);
    curReq = "R2"; busWrite(12'h400, 32'h000C_000F); busRead(12'h400);
    busWrite(12'h400, 32'h0000_0030); busRead(12'h400);
    busWrite(12'h400, 32'h0030_FFDC); busRead(12'h400);
    curReq = "R3"; busWrite(12'h400, 32'h000C_0004); busRead(12'h400);
    curReq = "R5"; busWrite(12'h404, 32'd1); busWrite(12'h400, 32'h0033_0003);
    busRead(12'h400); waitDone(); readAll();
    curReq = "R6"; busWrite(12'h400, 32'h0033_0013); waitDone(); readAll();
    curReq = "R4"; busWrite(12'h404, 32'd0); busWrite(12'h400, 32'h0033_0023); waitDone(); readAll();
    curReq = "R7"; busWrite(12'h404, 32'd3); busWrite(12'h400, 32'h0033_0033);
    for (int j = 0; j < 8; j++) busRead(12'h410 + 12'(j * 4));
    waitDone(); readAll();
    curReq = "R8"; busWrite(12'h404, 32'd2); busWrite(12'h400, 32'h0033_0001);
    idle(20); busRead(12'h400); idle(10); busRead(12'h400);
    busWrite(12'h400, 32'h0002_0002); waitDone(); readAll();
    curReq = "R9"; busWrite(12'h400, 32'h0001_0001); idle(30);
    busWrite(12'h400, 32'h0001_0000); readAll();
    busWrite(12'h404, 32'd1); busWrite(12'h400, 32'h0001_0001); waitDone(); readAll();
    curReq = "R10"; busWrite(12'h400, 32'h003F_003E); busWrite(12'h004, 32'h1); readAll();
    curReq = "R1"; idle(2);
    summary();
  end
endmodule